// File: doc/BRIEF.md
# Read Request to Bus Bridge

This block serves read requests that arrive as frames from a serial fabric. It pulls a request frame one 32-bit word at a time from an inbound packet buffer. If the frame is a read request, it turns the 4-bit size code and the word-pointer bit into a beat count and an 8-lane byte-select mask. It then runs one burst read on a 64-bit bus master port whose address counts doublewords. Last, it pushes a response frame word by word into an outbound packet buffer and commits it. Frames that are not read requests are released and nothing else happens.

The read data is kept in a small doubleword store that can map onto block RAM. The outbound frame therefore starts only after the burst has finished. This means a response frame is never left half written.

Frame layout:
- Request word 0: destination ID in bits 31:16, source ID in bits 15:0.
- Request word 1: frame class [31:28], transport code [27:26], transaction kind [23:20], size code [19:16], word pointer [15], transaction ID [7:0].
- Request word 2: doubleword base address in bits 30:0.
- A read request carries class 0010, transport 01 and kind 0100.
- Response word 0: the request's source ID in bits 31:16 and its destination ID in bits 15:0.
- Response word 1: class 1101, transport 01, kind [23:20], status [19:16], transaction ID [7:0].

Top module: `rdreq_bridge`

## Requirements
- R1: While and right after reset, rq_pull, rq_release, rs_push, rs_commit, wb_cyc and wb_stb are all low.
- R2: Size codes 0000, 0001, 0010 and 0011 each give one beat. The byte select is 80, 40, 20 or 10 hex with pointer 0, and 08, 04, 02 or 01 hex with pointer 1.
- R3: Size codes 0100 to 1010 each give one beat. The select, as (pointer 0 / pointer 1) in hex, is: 0100 C0/0C, 0101 E0/07, 0110 30/03, 0111 F8/1F, 1000 F0/0F, 1001 FC/3F, 1010 FE/7F.
- R4: Size codes 1011 to 1111 select FF hex. Their beat counts, as (pointer 0 / pointer 1), are 1/2, 4/8, 12/16, 20/24 and 28/32.
- R5: During a burst, wb_cyc and wb_stb stay high until the last beat is acknowledged, and wb_we is low. wb_sel does not change. wb_adr equals the base plus the number of beats acknowledged so far.
- R6: The slave may add any number of wait cycles before each wb_ack; the data returned is still correct.
- R7: A successful response has the IDs swapped, the transaction ID echoed, class 1101, transport 01, kind 1000 and status 0000.
- R8: After the two header words, each beat appears as two payload words, bits 63:32 first, with beats in address order. The frame is committed after the last payload word.
- R9: wb_err ends the burst. No further strobe is issued, and the response has kind 0000, status 0111 and no payload (two words).
- R10: A frame with the wrong class, kind or transport, or one that ends before three words, is released. It causes no bus cycle and no response.
- R11: The first word of a response is never pushed while rs_full is high. A commit always follows at least one pushed word.
- R12: rq_pull is never issued while rq_empty is high, and each request frame is released with exactly one rq_release pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rq_empty | input | 1 | High when no inbound frame is waiting |
| rq_last | input | 1 | Marks the word on rq_word as the last of its frame |
| rq_word | input | 32 | Inbound word, valid the cycle after an rq_pull cycle |
| rq_pull | output | 1 | One-cycle strobe that fetches the next inbound word |
| rq_release | output | 1 | One-cycle pulse that frees the current inbound frame |
| rs_full | input | 1 | High when the outbound buffer cannot take a new frame |
| rs_push | output | 1 | Strobe that writes rs_word into the outbound frame |
| rs_word | output | 32 | Outbound word |
| rs_commit | output | 1 | One-cycle pulse that finishes the outbound frame |
| wb_cyc | output | 1 | Bus cycle |
| wb_stb | output | 1 | Bus strobe |
| wb_we | output | 1 | Bus write enable, always low |
| wb_adr | output | 31 | Doubleword address |
| wb_sel | output | 8 | Byte lane select |
| wb_dat_i | input | 64 | Read data |
| wb_ack | input | 1 | Beat acknowledge |
| wb_err | input | 1 | Bus error |

## Verification
The bench covers every pairing of size code and word pointer. It checks the lane mask and beat count of each pairing. A single wrong entry in the decode shows up as a wrong wb_sel or as a short or long burst.

Slow acknowledges check that a design which captures data on a wait cycle, or moves the address early, is caught through the payload and the address checks. An error in mid-burst has to stop the strobe and produce a two-word error response; a design that kept reading would show extra strobes.

Other cases check the release path and the full flag:
- Non-read frames and truncated frames must be released with no bus cycle.
- A held full flag must hold back the first response word; a design that ignores it pushes early.

// File: rtl/rdreq_pkg.sv
package rdreq_pkg;
  localparam logic [3:0] FC_REQUEST  = 4'h2;
  localparam logic [3:0] FC_RESPONSE = 4'hD;
  localparam logic [3:0] KIND_READ   = 4'h4;
  localparam logic [3:0] KIND_DATA   = 4'h8;
  localparam logic [3:0] KIND_NODATA = 4'h0;
  localparam logic [1:0] TRANSPORT16 = 2'b01;
  localparam logic [3:0] STAT_OK     = 4'h0;
  localparam logic [3:0] STAT_ERR    = 4'h7;

  typedef enum logic [3:0] {
    S_IDLE, S_HREQ, S_HWAIT, S_HCAP, S_CHECK, S_RELEASE, S_GAP,
    S_BUS, S_OWAIT, S_HDR0, S_HDR1, S_FETCH, S_HI, S_LO, S_COMMIT
  } fsm_t;
endpackage

// File: rtl/rdreq_size_decode.sv
module rdreq_size_decode #(
  parameter int SEL_W  = 8,
  parameter int BEAT_W = 6
) (
  input  logic [3:0]        code,
  input  logic              ptr,
  output logic [SEL_W-1:0]  sel,
  output logic [BEAT_W-1:0] beats
);
  logic [7:0] m_lo, m_hi;
  logic [5:0] n_lo, n_hi;

  always_comb begin
    m_hi = 8'hFF; m_lo = 8'hFF;
    n_hi = 6'd1;  n_lo = 6'd1;
    case (code)
      4'h0: begin m_hi = 8'h80; m_lo = 8'h08; end
      4'h1: begin m_hi = 8'h40; m_lo = 8'h04; end
      4'h2: begin m_hi = 8'h20; m_lo = 8'h02; end
      4'h3: begin m_hi = 8'h10; m_lo = 8'h01; end
      4'h4: begin m_hi = 8'hC0; m_lo = 8'h0C; end
      4'h5: begin m_hi = 8'hE0; m_lo = 8'h07; end
      4'h6: begin m_hi = 8'h30; m_lo = 8'h03; end
      4'h7: begin m_hi = 8'hF8; m_lo = 8'h1F; end
      4'h8: begin m_hi = 8'hF0; m_lo = 8'h0F; end
      4'h9: begin m_hi = 8'hFC; m_lo = 8'h3F; end
      4'hA: begin m_hi = 8'hFE; m_lo = 8'h7F; end
      4'hB: begin n_hi = 6'd1;  n_lo = 6'd2;  end
      4'hC: begin n_hi = 6'd4;  n_lo = 6'd8;  end
      4'hD: begin n_hi = 6'd12; n_lo = 6'd16; end
      4'hE: begin n_hi = 6'd20; n_lo = 6'd24; end
      default: begin n_hi = 6'd28; n_lo = 6'd32; end
    endcase
    sel   = SEL_W'(ptr ? m_lo : m_hi);
    beats = BEAT_W'(ptr ? n_lo : n_hi);
  end
endmodule

// File: rtl/rdreq_beat_store.sv
module rdreq_beat_store #(
  parameter int DEPTH = 32,
  parameter int WIDTH = 64
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [WIDTH-1:0]         wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [WIDTH-1:0]         rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/rdreq_burst.sv
module rdreq_burst #(
  parameter int ADR_W  = 31,
  parameter int SEL_W  = 8,
  parameter int BEAT_W = 6,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADR_W-1:0]  base,
  input  logic [SEL_W-1:0]  sel_in,
  input  logic [BEAT_W-1:0] beats,
  output logic              wb_cyc,
  output logic              wb_stb,
  output logic [ADR_W-1:0]  wb_adr,
  output logic [SEL_W-1:0]  wb_sel,
  input  logic              wb_ack,
  input  logic              wb_err,
  output logic              st_we,
  output logic [IDX_W-1:0]  st_idx,
  output logic              done,
  output logic              failed
);
  logic [BEAT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_cyc <= 1'b0; wb_stb <= 1'b0; wb_adr <= '0; wb_sel <= '0;
      cnt <= '0; done <= 1'b0; failed <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !wb_cyc) begin
        wb_cyc <= 1'b1; wb_stb <= 1'b1;
        wb_adr <= base; wb_sel <= sel_in;
        cnt <= '0; failed <= 1'b0;
      end else if (wb_cyc && wb_err) begin
        wb_cyc <= 1'b0; wb_stb <= 1'b0;
        done <= 1'b1; failed <= 1'b1;
      end else if (wb_cyc && wb_ack) begin
        wb_adr <= wb_adr + ADR_W'(1);
        cnt    <= cnt + BEAT_W'(1);
        if (cnt == beats - BEAT_W'(1)) begin
          wb_cyc <= 1'b0; wb_stb <= 1'b0; done <= 1'b1;
        end
      end
    end
  end

  assign st_we  = wb_cyc && wb_ack && !wb_err;
  assign st_idx = cnt[IDX_W-1:0];

  // R5: lane select held for the whole burst
  a_r5_sel_hold: assert property (@(posedge clk) disable iff (rst)
    (wb_cyc && $past(wb_cyc)) |-> $stable(wb_sel));
  // R5: address steps by one doubleword after each acknowledged beat
  a_r5_adr_step: assert property (@(posedge clk) disable iff (rst)
    (wb_cyc && $past(wb_cyc && wb_ack && !wb_err)) |-> (wb_adr == $past(wb_adr) + ADR_W'(1)));
  // R9: a bus error closes the cycle on the next edge
  a_r9_err_close: assert property (@(posedge clk) disable iff (rst)
    (wb_cyc && wb_err) |=> !wb_cyc);
endmodule

// File: rtl/rdreq_bridge.sv
module rdreq_bridge #(
  parameter int ADR_W     = 31,
  parameter int DAT_W     = 64,
  parameter int WORD_W    = 32,
  parameter int MAX_BEATS = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rq_empty,
  input  logic              rq_last,
  input  logic [WORD_W-1:0] rq_word,
  output logic              rq_pull,
  output logic              rq_release,
  input  logic              rs_full,
  output logic              rs_push,
  output logic [WORD_W-1:0] rs_word,
  output logic              rs_commit,
  output logic              wb_cyc,
  output logic              wb_stb,
  output logic              wb_we,
  output logic [ADR_W-1:0]  wb_adr,
  output logic [DAT_W/8-1:0] wb_sel,
  input  logic [DAT_W-1:0]  wb_dat_i,
  input  logic              wb_ack,
  input  logic              wb_err
);
  import rdreq_pkg::*;

  localparam int SEL_W  = DAT_W / 8;
  localparam int BEAT_W = $clog2(MAX_BEATS + 1);
  localparam int IDX_W  = $clog2(MAX_BEATS);

  fsm_t state;
  logic [1:0]        hcnt;
  logic [WORD_W-1:0] hdr0, hdr1, hdr2;
  logic              whole, is_read, go;
  logic [BEAT_W-1:0] beats_q, dec_beats;
  logic [SEL_W-1:0]  dec_sel;
  logic [IDX_W-1:0]  rd_idx, st_idx;
  logic [DAT_W-1:0]  rd_q;
  logic              st_we, bus_done, bus_failed;

  wire [3:0] f_class = hdr1[31:28];
  wire [1:0] f_trans = hdr1[27:26];
  wire [3:0] f_kind  = hdr1[23:20];
  wire [7:0] f_tid   = hdr1[7:0];
  logic unused_bits;
  assign unused_bits = ^{hdr1[25:24], hdr1[14:8], hdr2[WORD_W-1:ADR_W]};

  rdreq_size_decode #(.SEL_W(SEL_W), .BEAT_W(BEAT_W)) u_dec (
    .code(hdr1[19:16]), .ptr(hdr1[15]), .sel(dec_sel), .beats(dec_beats));

  rdreq_burst #(.ADR_W(ADR_W), .SEL_W(SEL_W), .BEAT_W(BEAT_W), .IDX_W(IDX_W)) u_bus (
    .clk(clk), .rst(rst), .start(go), .base(hdr2[ADR_W-1:0]), .sel_in(dec_sel),
    .beats(beats_q), .wb_cyc(wb_cyc), .wb_stb(wb_stb), .wb_adr(wb_adr), .wb_sel(wb_sel),
    .wb_ack(wb_ack), .wb_err(wb_err), .st_we(st_we), .st_idx(st_idx),
    .done(bus_done), .failed(bus_failed));

  rdreq_beat_store #(.DEPTH(MAX_BEATS), .WIDTH(DAT_W)) u_store (
    .clk(clk), .we(st_we), .waddr(st_idx), .wdata(wb_dat_i),
    .raddr(rd_idx), .rdata(rd_q));

  assign wb_we = 1'b0;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= S_IDLE; hcnt <= '0; whole <= 1'b0; is_read <= 1'b0; go <= 1'b0;
      beats_q <= '0; rd_idx <= '0; hdr0 <= '0; hdr1 <= '0; hdr2 <= '0;
      rq_pull <= 1'b0; rq_release <= 1'b0;
      rs_push <= 1'b0; rs_word <= '0; rs_commit <= 1'b0;
    end else begin
      rq_pull <= 1'b0; rq_release <= 1'b0;
      rs_push <= 1'b0; rs_commit <= 1'b0; go <= 1'b0;
      case (state)
        S_IDLE:  if (!rq_empty) begin hcnt <= '0; state <= S_HREQ; end
        S_HREQ:  begin rq_pull <= 1'b1; state <= S_HWAIT; end
        S_HWAIT: state <= S_HCAP;
        S_HCAP: begin
          case (hcnt)
            2'd0:    hdr0 <= rq_word;
            2'd1:    hdr1 <= rq_word;
            default: hdr2 <= rq_word;
          endcase
          if (rq_last || hcnt == 2'd2) begin
            whole <= (hcnt == 2'd2);
            state <= S_CHECK;
          end else begin
            hcnt  <= hcnt + 2'd1;
            state <= S_HREQ;
          end
        end
        S_CHECK: begin
          is_read <= whole && f_class == FC_REQUEST && f_trans == TRANSPORT16
                     && f_kind == KIND_READ;
          beats_q <= dec_beats;
          state   <= S_RELEASE;
        end
        S_RELEASE: begin rq_release <= 1'b1; state <= S_GAP; end
        S_GAP: if (is_read) begin go <= 1'b1; state <= S_BUS; end
               else state <= S_IDLE;
        S_BUS:   if (bus_done) state <= S_OWAIT;
        S_OWAIT: if (!rs_full) state <= S_HDR0;
        S_HDR0: begin
          rs_push <= 1'b1; rs_word <= {hdr0[15:0], hdr0[31:16]};
          state <= S_HDR1;
        end
        S_HDR1: begin
          rs_push <= 1'b1;
          rs_word <= {FC_RESPONSE, TRANSPORT16, 2'b00,
                      bus_failed ? KIND_NODATA : KIND_DATA,
                      bus_failed ? STAT_ERR : STAT_OK, 8'h00, f_tid};
          rd_idx <= '0;
          state  <= bus_failed ? S_COMMIT : S_FETCH;
        end
        S_FETCH: state <= S_HI;
        S_HI: begin
          rs_push <= 1'b1; rs_word <= rd_q[DAT_W-1:DAT_W-WORD_W];
          state <= S_LO;
        end
        S_LO: begin
          rs_push <= 1'b1; rs_word <= rd_q[WORD_W-1:0];
          if (BEAT_W'(rd_idx) == beats_q - BEAT_W'(1)) state <= S_COMMIT;
          else begin rd_idx <= rd_idx + IDX_W'(1); state <= S_FETCH; end
        end
        S_COMMIT: begin rs_commit <= 1'b1; state <= S_IDLE; end
        default:  state <= S_IDLE;
      endcase
    end
  end

  // R11: a commit is always preceded by a pushed word
  a_r11_commit_after_push: assert property (@(posedge clk) disable iff (rst)
    rs_commit |-> $past(rs_push));
  // R11: nothing is written to the response while the burst runs
  a_r11_quiet_bus: assert property (@(posedge clk) disable iff (rst)
    wb_cyc |-> (!rs_push && !rs_commit));
  // R12: release is a single-cycle pulse
  a_r12_release_once: assert property (@(posedge clk) disable iff (rst)
    rq_release |=> !rq_release);
  // R10: a rejected frame starts no bus cycle
  a_r10_no_bus: assert property (@(posedge clk) disable iff (rst)
    (state == S_GAP && !is_read) |=> !wb_cyc);
endmodule

// File: tb/sim_rdreq_bridge.sv
`timescale 1ns/1ps
module sim_rdreq_bridge;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic        rq_empty, rq_last, rq_pull, rq_release;
  logic [31:0] rq_word;
  logic        rs_full, rs_push, rs_commit;
  logic [31:0] rs_word;
  logic        wb_cyc, wb_stb, wb_we, wb_ack, wb_err;
  logic [30:0] wb_adr;
  logic [7:0]  wb_sel;
  logic [63:0] wb_dat;

  rdreq_bridge u0 (
    .clk(clk), .rst(rst), .rq_empty(rq_empty), .rq_last(rq_last), .rq_word(rq_word),
    .rq_pull(rq_pull), .rq_release(rq_release), .rs_full(rs_full), .rs_push(rs_push),
    .rs_word(rs_word), .rs_commit(rs_commit), .wb_cyc(wb_cyc), .wb_stb(wb_stb),
    .wb_we(wb_we), .wb_adr(wb_adr), .wb_sel(wb_sel), .wb_dat_i(wb_dat),
    .wb_ack(wb_ack), .wb_err(wb_err));

  int checks = 0;
  int bad = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] pat(input logic [30:0] a);
    return {1'b1, a, 1'b0, a ^ 31'h2AAA_5555};
  endfunction

  // ---- models ----
  logic        m_clr = 1'b0, load = 1'b0;
  logic [31:0] ibuf [0:2];
  int          ilen = 3;
  logic        has_frame;
  int          iptr, releases, pull_bad;
  assign rq_empty = !has_frame;

  always @(posedge clk) begin
    if (m_clr) begin
      has_frame <= 1'b0; iptr <= 0; releases <= 0; pull_bad <= 0;
      rq_word <= '0; rq_last <= 1'b0;
    end else begin
      if (load) begin has_frame <= 1'b1; iptr <= 0; end
      if (rq_pull) begin
        if (!has_frame) pull_bad <= pull_bad + 1;
        rq_word <= ibuf[iptr];
        rq_last <= (iptr == ilen - 1);
        iptr <= iptr + 1;
      end
      if (rq_release) begin has_frame <= 1'b0; releases <= releases + 1; end
    end
  end

  logic [31:0] obuf [0:127];
  int ocnt, frames, olen, zero_commit, full_bad;
  always @(posedge clk) begin
    if (m_clr) begin
      ocnt <= 0; frames <= 0; olen <= 0; zero_commit <= 0; full_bad <= 0;
    end else begin
      if (rs_push) begin
        if (rs_full && ocnt == 0) full_bad <= full_bad + 1;
        obuf[ocnt] <= rs_word;
        ocnt <= ocnt + 1;
      end
      if (rs_commit) begin
        frames <= frames + 1; olen <= ocnt; ocnt <= 0;
        if (ocnt == 0) zero_commit <= zero_commit + 1;
      end
    end
  end

  logic [30:0] s_base = '0;
  logic [7:0]  s_sel = '0;
  int          s_lat = 0, s_errb = 99;
  int          acks, wcnt, cyc_seen, sel_bad, adr_bad, post_err;
  logic        err_sent;
  always @(posedge clk) begin
    if (m_clr) begin
      acks <= 0; wcnt <= 0; cyc_seen <= 0; sel_bad <= 0; adr_bad <= 0; post_err <= 0;
      err_sent <= 1'b0; wb_ack <= 1'b0; wb_err <= 1'b0; wb_dat <= '0;
    end else begin
      wb_ack <= 1'b0; wb_err <= 1'b0;
      if (wb_cyc) cyc_seen <= cyc_seen + 1;
      if (wb_cyc && wb_stb && !wb_ack && !wb_err) begin
        if (err_sent) post_err <= post_err + 1;
        if (wb_sel !== s_sel || wb_we !== 1'b0) sel_bad <= sel_bad + 1;
        if (wb_adr !== s_base + 31'(acks)) adr_bad <= adr_bad + 1;
        if (wcnt == s_lat) begin
          wcnt <= 0;
          if (acks == s_errb) begin wb_err <= 1'b1; err_sent <= 1'b1; end
          else begin wb_ack <= 1'b1; wb_dat <= pat(wb_adr); acks <= acks + 1; end
        end else wcnt <= wcnt + 1;
      end
    end
  end

  // ---- stimulus helpers ----
  task automatic clear_models();
    @(negedge clk); m_clr = 1'b1;
    @(negedge clk); m_clr = 1'b0;
  endtask

  task automatic send(input logic [31:0] w0, input logic [31:0] w1, input logic [31:0] w2, input int n);
    @(negedge clk);
    ibuf[0] = w0; ibuf[1] = w1; ibuf[2] = w2; ilen = n; load = 1'b1;
    @(negedge clk); load = 1'b0;
  endtask

  function automatic logic [31:0] req_w1(input logic [3:0] kind, input logic [3:0] code,
                                         input logic ptr, input logic [7:0] tid);
    return {4'h2, 2'b01, 2'b00, kind, code, ptr, 7'b0, tid};
  endfunction

  task automatic wait_frame();
    for (int g = 0; g < 4000 && frames == 0; g++) @(negedge clk);
  endtask

  task automatic do_read(input logic [3:0] code, input logic ptr, input logic [30:0] base,
                         input int lat, input logic [7:0] xsel, input int xbeats, input string stag);
    logic [15:0] dst, src;
    logic [7:0]  tid;
    bit ok;
    logic [31:0] a, e;
    dst = 16'h1100 + 16'(code); src = 16'h2200 + 16'(ptr); tid = {code, 3'b0, ptr};
    clear_models();
    s_base = base; s_sel = xsel; s_lat = lat; s_errb = 99;
    send({dst, src}, req_w1(4'h4, code, ptr, tid), {1'b0, base}, 3);
    wait_frame();
    repeat (2) @(negedge clk);
    chk(acks == xbeats && sel_bad == 0, $sformatf("%s beats/sel code=%h ptr=%0d", stag, code, ptr),
        64'(acks), 64'(xbeats));
    chk(adr_bad == 0, "R5 burst address", 64'(adr_bad), 64'd0);
    chk(frames == 1 && olen == 2 + 2 * xbeats, "R8 response length", 64'(olen), 64'(2 + 2 * xbeats));
    chk(obuf[0] == {src, dst} && obuf[1] == {4'hD, 2'b01, 2'b00, 4'h8, 4'h0, 8'h00, tid},
        "R7 response header", {obuf[0], obuf[1]},
        {src, dst, 4'hD, 2'b01, 2'b00, 4'h8, 4'h0, 8'h00, tid});
    ok = 1'b1; a = '0; e = '0;
    for (int k = 0; k < xbeats; k++) begin
      logic [63:0] d;
      d = pat(base + 31'(k));
      if (ok && obuf[2 + 2 * k] !== d[63:32]) begin ok = 1'b0; a = obuf[2 + 2 * k]; e = d[63:32]; end
      if (ok && obuf[3 + 2 * k] !== d[31:0])  begin ok = 1'b0; a = obuf[3 + 2 * k]; e = d[31:0]; end
    end
    chk(ok, "R8 payload order", 64'(a), 64'(e));
    chk(releases == 1 && pull_bad == 0, "R12 one release, no empty pull", 64'(releases), 64'd1);
  endtask

  // code, ptr, beats, mask
  localparam logic [18:0] VEC [32] = '{
    {4'h0,1'b0,6'd1,8'h80}, {4'h0,1'b1,6'd1,8'h08},
    {4'h1,1'b0,6'd1,8'h40}, {4'h1,1'b1,6'd1,8'h04},
    {4'h2,1'b0,6'd1,8'h20}, {4'h2,1'b1,6'd1,8'h02},
    {4'h3,1'b0,6'd1,8'h10}, {4'h3,1'b1,6'd1,8'h01},
    {4'h4,1'b0,6'd1,8'hC0}, {4'h4,1'b1,6'd1,8'h0C},
    {4'h5,1'b0,6'd1,8'hE0}, {4'h5,1'b1,6'd1,8'h07},
    {4'h6,1'b0,6'd1,8'h30}, {4'h6,1'b1,6'd1,8'h03},
    {4'h7,1'b0,6'd1,8'hF8}, {4'h7,1'b1,6'd1,8'h1F},
    {4'h8,1'b0,6'd1,8'hF0}, {4'h8,1'b1,6'd1,8'h0F},
    {4'h9,1'b0,6'd1,8'hFC}, {4'h9,1'b1,6'd1,8'h3F},
    {4'hA,1'b0,6'd1,8'hFE}, {4'hA,1'b1,6'd1,8'h7F},
    {4'hB,1'b0,6'd1,8'hFF}, {4'hB,1'b1,6'd2,8'hFF},
    {4'hC,1'b0,6'd4,8'hFF}, {4'hC,1'b1,6'd8,8'hFF},
    {4'hD,1'b0,6'd12,8'hFF}, {4'hD,1'b1,6'd16,8'hFF},
    {4'hE,1'b0,6'd20,8'hFF}, {4'hE,1'b1,6'd24,8'hFF},
    {4'hF,1'b0,6'd28,8'hFF}, {4'hF,1'b1,6'd32,8'hFF}
  };

  initial begin
    rs_full = 1'b0;
    ibuf[0] = '0; ibuf[1] = '0; ibuf[2] = '0;
    m_clr = 1'b1;
    repeat (4) @(negedge clk);
    m_clr = 1'b0;
    // R1: outputs idle in reset
    chk(!rq_pull && !rq_release && !rs_push && !rs_commit && !wb_cyc && !wb_stb,
        "R1 reset outputs", {58'd0, rq_pull, rq_release, rs_push, rs_commit, wb_cyc, wb_stb}, 64'd0);
    @(negedge clk); rst = 1'b0;
    repeat (3) @(negedge clk);
    chk(!rq_pull && !rq_release && !rs_push && !rs_commit && !wb_cyc && !wb_stb,
        "R1 idle after reset", {58'd0, rq_pull, rq_release, rs_push, rs_commit, wb_cyc, wb_stb}, 64'd0);

    // Table: R2 single-byte, R3 partial, R4 multi-doubleword
    for (int i = 0; i < 32; i++) begin
      logic [3:0] c;
      c = VEC[i][18:15];
      do_read(c, VEC[i][14], 31'(i * 64 + 5), i % 3, VEC[i][7:0], int'(VEC[i][13:8]),
              c < 4'h4 ? "R2" : (c < 4'hB ? "R3" : "R4"));
    end

    // R6: long wait states before every ack
    do_read(4'hC, 1'b1, 31'h1234, 5, 8'hFF, 8, "R6");

    // R9: error on the fourth beat of a 12-beat burst
    clear_models();
    s_base = 31'h0400; s_sel = 8'hFF; s_lat = 1; s_errb = 3;
    send({16'hAAAA, 16'h5555}, req_w1(4'h4, 4'hD, 1'b0, 8'h3C), {1'b0, 31'h0400}, 3);
    wait_frame();
    repeat (2) @(negedge clk);
    chk(acks == 3 && post_err == 0 && !wb_cyc, "R9 burst stops at error", 64'(acks + post_err), 64'd3);
    chk(frames == 1 && olen == 2, "R9 header-only response", 64'(olen), 64'd2);
    chk(obuf[1] == {4'hD, 2'b01, 2'b00, 4'h0, 4'h7, 8'h00, 8'h3C} && obuf[0] == {16'h5555, 16'hAAAA},
        "R9 error header", {obuf[0], obuf[1]},
        {16'h5555, 16'hAAAA, 4'hD, 2'b01, 2'b00, 4'h0, 4'h7, 8'h00, 8'h3C});

    // R10: wrong transaction kind
    clear_models();
    send({16'h0001, 16'h0002}, req_w1(4'h5, 4'hB, 1'b0, 8'h01), 32'h0000_0100, 3);
    repeat (60) @(negedge clk);
    chk(releases == 1 && cyc_seen == 0 && frames == 0 && ocnt == 0, "R10 non-read released",
        {32'(releases), 32'(cyc_seen + frames)}, {32'd1, 32'd0});
    // R10: frame too short
    clear_models();
    send({16'h0001, 16'h0002}, req_w1(4'h4, 4'hB, 1'b0, 8'h02), 32'h0, 2);
    repeat (60) @(negedge clk);
    chk(releases == 1 && cyc_seen == 0 && frames == 0 && ocnt == 0, "R10 short frame released",
        {32'(releases), 32'(cyc_seen + frames)}, {32'd1, 32'd0});

    // R11: response held back while the outbound buffer is full
    clear_models();
    rs_full = 1'b1;
    s_base = 31'h0077; s_sel = 8'hFF; s_lat = 0; s_errb = 99;
    send({16'h0010, 16'h0020}, req_w1(4'h4, 4'hC, 1'b0, 8'h44), {1'b0, 31'h0077}, 3);
    repeat (150) @(negedge clk);
    chk(acks == 4 && ocnt == 0 && frames == 0, "R11 no push while full", 64'(ocnt + frames), 64'd0);
    rs_full = 1'b0;
    wait_frame();
    repeat (2) @(negedge clk);
    chk(frames == 1 && olen == 10 && full_bad == 0, "R11 frame after full drops", 64'(olen), 64'd10);
    chk(zero_commit == 0, "R11 no empty commit", 64'(zero_commit), 64'd0);
    chk(pull_bad == 0, "R12 no pull while empty", 64'(pull_bad), 64'd0);

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; bad++;
    $display("FAIL R12 watchdog act=%0d exp=%0d", 150000, 0);
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule